// File: doc/BRIEF.md
# Timer Output Flag Generator

This block forms the one-bit output of a counter/timer channel. It does not count or compare. It takes event pulses from the channel's counter datapath and turns them into an output flag according to a 3-bit output mode. The events are compare hits from two comparators, a counter-active level, a rollover pulse, a secondary-input edge pulse and the count tick. A software force path loads a chosen value into the flag. A debug override, the polarity inversion and the pin output enable are applied after the mode logic, in that order.

The flag is a register for the event-driven modes (clear, set, toggle, alternating toggle, and the two set/clear pairs). The active-level mode and the gated-clock mode are combinational views of the counter state, so they follow it in the same cycle. Every pin is a plain level or a single-cycle pulse sampled on the rising clock edge. Nothing flows as a data stream, so the block has no handshake.

Top module: `timer_oflag_gen`

## Requirements
- R1: After reset the flag register holds 0 and the alternating-compare selector expects comparator 1 first, so in mode 010 `flag_o` reads 0 straight out of reset.
- R2: In mode 000, `flag_o` equals `cnt_active_i` in the same cycle.
- R3: In modes 001, 010 and 011, a compare hit (`cmp1_hit_i` or `cmp2_hit_i`) clears, sets or inverts the flag respectively, effective on the next cycle. Rollover and secondary-edge pulses leave the flag unchanged in these modes.
- R4: In mode 100 the flag inverts only on a hit from the comparator currently expected. Expectation starts at comparator 1 and swaps after each accepted hit. A hit from the other comparator is ignored. Leaving mode 100 returns the expectation to comparator 1.
- R5: In mode 101 a compare hit sets the flag and a `sec_edge_i` pulse clears it. When both arrive in one cycle the set wins.
- R6: In mode 110 a compare hit sets the flag and a `rollover_i` pulse clears it. When both arrive in one cycle the set wins.
- R7: In mode 111, `flag_o` equals `tick_i & cnt_active_i` in the same cycle.
- R8: A cycle with `force_wr_i` high loads `force_val_i` into the flag register on the next cycle, overriding any mode event. In modes 000 and 111 the register holds its value and is not shown.
- R9: When `dbg_active_i` is high and bit 1 of `dbg_ctl_i` is set (codes 10 and 11), the value sent to the pin is 0 before polarity. `flag_o` is not affected.
- R10: With `pol_inv_i` high the pin value is the inverse of the post-debug flag; with it low the value passes unchanged.
- R11: `pin_oe_o` follows `oe_i`. While `oe_i` is low, `pin_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Output mode select |
| cmp1_hit_i | input | 1 | Comparator 1 match pulse |
| cmp2_hit_i | input | 1 | Comparator 2 match pulse |
| cnt_active_i | input | 1 | Counter is counting |
| rollover_i | input | 1 | Counter rollover pulse |
| sec_edge_i | input | 1 | Secondary-input edge pulse |
| tick_i | input | 1 | Count tick for gated-clock output |
| force_wr_i | input | 1 | Force strobe |
| force_val_i | input | 1 | Value loaded by the force strobe |
| dbg_active_i | input | 1 | Chip is in debug state |
| dbg_ctl_i | input | 2 | Debug action code; bit 1 forces the output low |
| pol_inv_i | input | 1 | Invert pin polarity |
| oe_i | input | 1 | Drive the pin with the flag |
| flag_o | output | 1 | Raw flag after mode logic |
| pin_data_o | output | 1 | Data to the pin driver |
| pin_oe_o | output | 1 | Output enable to the pin driver |

## Verification
The bench builds the block with its default parameters: the flag resets to 0 and bit 1 of the debug code is the force-low bit. This makes the reset-state checks meaningful and lets a bench function predict every cycle from an all-zero start. Random stimulus changes mode every few dozen cycles, which walks the alternating-compare selector through mode exits and re-entries. Directed cycles place a set together with a clear in the same cycle, place the wrong comparator's hit in alternating mode, and place a force on top of a compare hit.

// File: rtl/tof_pkg.sv
package tof_pkg;
  localparam int MODE_W = 3;
  localparam int DBG_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    OM_ACTIVE   = 3'd0,
    OM_CLR      = 3'd1,
    OM_SET      = 3'd2,
    OM_TGL      = 3'd3,
    OM_ALT      = 3'd4,
    OM_SET_SEC  = 3'd5,
    OM_SET_ROLL = 3'd6,
    OM_GATE     = 3'd7
  } omode_e;
endpackage

// File: rtl/tof_alt_sel.sv
module tof_alt_sel
  import tof_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  omode_e mode,
  input  logic   cmp1_hit,
  input  logic   cmp2_hit,
  output logic   alt_hit
);
  // expect_two: 0 = waiting for comparator 1, 1 = waiting for comparator 2
  logic expect_two;

  assign alt_hit = (mode == OM_ALT) && (expect_two ? cmp2_hit : cmp1_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                expect_two <= 1'b0;
    else if (mode != OM_ALT)   expect_two <= 1'b0;
    else if (alt_hit)          expect_two <= ~expect_two;
  end

  assert_alt_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OM_ALT && alt_hit) |=> (expect_two != $past(expect_two)));

  assert_alt_home_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != OM_ALT) |=> !expect_two);
endmodule

// File: rtl/tof_flag_core.sv
module tof_flag_core
  import tof_pkg::*;
#(
  parameter logic FLAG_RST = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  omode_e mode,
  input  logic   cmp_any,
  input  logic   alt_hit,
  input  logic   sec_edge,
  input  logic   rollover,
  input  logic   force_wr,
  input  logic   force_val,
  output logic   flag_q
);
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (force_wr) begin
      flag_d = force_val;
    end else begin
      unique case (mode)
        OM_CLR:      if (cmp_any) flag_d = 1'b0;
        OM_SET:      if (cmp_any) flag_d = 1'b1;
        OM_TGL:      if (cmp_any) flag_d = ~flag_q;
        OM_ALT:      if (alt_hit) flag_d = ~flag_q;
        OM_SET_SEC:  if (cmp_any) flag_d = 1'b1;
                     else if (sec_edge) flag_d = 1'b0;
        OM_SET_ROLL: if (cmp_any) flag_d = 1'b1;
                     else if (rollover) flag_d = 1'b0;
        default:     flag_d = flag_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= FLAG_RST;
    else        flag_q <= flag_d;
  end

  assert_force_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_wr |=> (flag_q == $past(force_val)));

  assert_set_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OM_SET && cmp_any && !force_wr) |=> flag_q);

  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OM_TGL && cmp_any && !force_wr) |=> (flag_q != $past(flag_q)));

  assert_sec_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OM_SET_SEC && sec_edge && !cmp_any && !force_wr) |=> !flag_q);

  assert_roll_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OM_SET_ROLL && rollover && !cmp_any && !force_wr) |=> !flag_q);

  assert_hold_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == OM_GATE || mode == OM_ACTIVE) && !force_wr) |=> $stable(flag_q));
endmodule

// File: rtl/tof_pin_stage.sv
module tof_pin_stage
  import tof_pkg::*;
#(
  parameter int DBG_LOW_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_flag,
  input  logic             dbg_active,
  input  logic [DBG_W-1:0] dbg_ctl,
  input  logic             pol_inv,
  input  logic             oe,
  output logic             pin_data,
  output logic             pin_oe
);
  logic dbg_low;
  logic post_dbg;

  assign dbg_low  = dbg_active & dbg_ctl[DBG_LOW_BIT];
  assign post_dbg = dbg_low ? 1'b0 : raw_flag;
  assign pin_data = oe & (post_dbg ^ pol_inv);
  assign pin_oe   = oe;

  assert_dbg_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_low && oe) |-> (pin_data == pol_inv));

  assert_quiet_pin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!pin_data && !pin_oe));
endmodule

// File: rtl/timer_oflag_gen.sv
module timer_oflag_gen
  import tof_pkg::*;
#(
  parameter logic FLAG_RST    = 1'b0,
  parameter int   DBG_LOW_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic             cmp1_hit_i,
  input  logic             cmp2_hit_i,
  input  logic             cnt_active_i,
  input  logic             rollover_i,
  input  logic             sec_edge_i,
  input  logic             tick_i,
  input  logic             force_wr_i,
  input  logic             force_val_i,
  input  logic             dbg_active_i,
  input  logic [DBG_W-1:0] dbg_ctl_i,
  input  logic             pol_inv_i,
  input  logic             oe_i,
  output logic             flag_o,
  output logic             pin_data_o,
  output logic             pin_oe_o
);
  omode_e mode;
  logic   alt_hit;
  logic   flag_q;
  logic   raw_flag;

  assign mode = omode_e'(mode_i);

  tof_alt_sel u_alt (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .cmp1_hit (cmp1_hit_i),
    .cmp2_hit (cmp2_hit_i),
    .alt_hit  (alt_hit)
  );

  tof_flag_core #(.FLAG_RST(FLAG_RST)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .cmp_any   (cmp1_hit_i | cmp2_hit_i),
    .alt_hit   (alt_hit),
    .sec_edge  (sec_edge_i),
    .rollover  (rollover_i),
    .force_wr  (force_wr_i),
    .force_val (force_val_i),
    .flag_q    (flag_q)
  );

  always_comb begin
    unique case (mode)
      OM_ACTIVE: raw_flag = cnt_active_i;
      OM_GATE:   raw_flag = tick_i & cnt_active_i;
      default:   raw_flag = flag_q;
    endcase
  end

  assign flag_o = raw_flag;

  tof_pin_stage #(.DBG_LOW_BIT(DBG_LOW_BIT)) u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_flag   (raw_flag),
    .dbg_active (dbg_active_i),
    .dbg_ctl    (dbg_ctl_i),
    .pol_inv    (pol_inv_i),
    .oe         (oe_i),
    .pin_data   (pin_data_o),
    .pin_oe     (pin_oe_o)
  );

  assert_gate_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OM_GATE && !cnt_active_i) |-> !flag_o);

  assert_active_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OM_ACTIVE) |-> (flag_o == cnt_active_i));
endmodule

// File: tb/timer_oflag_gen_bench.sv
`timescale 1ns/1ps
module timer_oflag_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic cmp1_hit_i = 0, cmp2_hit_i = 0, cnt_active_i = 0, rollover_i = 0;
  logic sec_edge_i = 0, tick_i = 0, force_wr_i = 0, force_val_i = 0;
  logic dbg_active_i = 0, pol_inv_i = 0, oe_i = 0;
  logic [1:0] dbg_ctl_i = 2'd0;
  logic flag_o, pin_data_o, pin_oe_o;

  int checks = 0;
  int errors = 0;
  logic m_flag = 1'b0;
  logic m_two  = 1'b0;
  logic done   = 1'b0;

  always #2.5 clk = ~clk;

  timer_oflag_gen u_timer_oflag_gen (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .cmp1_hit_i(cmp1_hit_i), .cmp2_hit_i(cmp2_hit_i),
    .cnt_active_i(cnt_active_i), .rollover_i(rollover_i),
    .sec_edge_i(sec_edge_i), .tick_i(tick_i),
    .force_wr_i(force_wr_i), .force_val_i(force_val_i),
    .dbg_active_i(dbg_active_i), .dbg_ctl_i(dbg_ctl_i),
    .pol_inv_i(pol_inv_i), .oe_i(oe_i),
    .flag_o(flag_o), .pin_data_o(pin_data_o), .pin_oe_o(pin_oe_o)
  );

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1, 3'd2, 3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic exp_raw();
    case (mode_i)
      3'd0: return cnt_active_i;
      3'd7: return tick_i & cnt_active_i;
      default: return m_flag;
    endcase
  endfunction

  function automatic logic exp_pin();
    logic v;
    v = (dbg_active_i && dbg_ctl_i[1]) ? 1'b0 : exp_raw();
    return oe_i ? (v ^ pol_inv_i) : 1'b0;
  endfunction

  function automatic logic alt_ok();
    return (mode_i == 3'd4) && (m_two ? cmp2_hit_i : cmp1_hit_i);
  endfunction

  function automatic logic next_flag();
    logic hit;
    hit = cmp1_hit_i | cmp2_hit_i;
    if (force_wr_i) return force_val_i;
    case (mode_i)
      3'd1: return hit ? 1'b0 : m_flag;
      3'd2: return hit ? 1'b1 : m_flag;
      3'd3: return hit ? ~m_flag : m_flag;
      3'd4: return alt_ok() ? ~m_flag : m_flag;
      3'd5: return hit ? 1'b1 : (sec_edge_i ? 1'b0 : m_flag);
      3'd6: return hit ? 1'b1 : (rollover_i ? 1'b0 : m_flag);
      default: return m_flag;
    endcase
  endfunction

  function automatic logic next_two();
    if (mode_i != 3'd4) return 1'b0;
    return alt_ok() ? ~m_two : m_two;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // inputs already driven after a negedge; check, then advance one clock
  task automatic step();
    logic nf, nt;
    string ptag;
    #1;
    check(mode_tag(mode_i), "flag_o", flag_o, exp_raw());
    if (!oe_i) ptag = "R11";
    else if (dbg_active_i && dbg_ctl_i[1]) ptag = "R9";
    else if (pol_inv_i) ptag = "R10";
    else ptag = mode_tag(mode_i);
    check(ptag, "pin_data_o", pin_data_o, exp_pin());
    check("R11", "pin_oe_o", pin_oe_o, oe_i);
    nf = next_flag();
    nt = next_two();
    @(posedge clk);
    m_flag = nf;
    m_two  = nt;
    @(negedge clk);
  endtask

  task automatic idle();
    cmp1_hit_i = 0; cmp2_hit_i = 0; rollover_i = 0; sec_edge_i = 0;
    force_wr_i = 0; tick_i = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_7A11);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset value visible in mode 2, pin enabled
    mode_i = 3'd2; oe_i = 1;
    #1;
    check("R1", "flag_o after reset", flag_o, 1'b0);
    check("R1", "pin_data_o after reset", pin_data_o, 1'b0);
    @(negedge clk);

    // R4 directed: wrong comparator first is ignored
    mode_i = 3'd4; idle(); step();
    cmp2_hit_i = 1; step(); idle();
    check("R4", "ignored cmp2 first", flag_o, 1'b0);
    cmp1_hit_i = 1; step(); idle();
    check("R4", "cmp1 toggles", flag_o, 1'b1);
    cmp1_hit_i = 1; step(); idle();
    check("R4", "repeat cmp1 ignored", flag_o, 1'b1);
    cmp2_hit_i = 1; step(); idle();
    check("R4", "cmp2 toggles back", flag_o, 1'b0);

    // R5 directed: set wins over secondary edge
    mode_i = 3'd5; cmp1_hit_i = 1; sec_edge_i = 1; step(); idle();
    check("R5", "set beats sec edge", flag_o, 1'b1);
    sec_edge_i = 1; step(); idle();
    check("R5", "sec edge clears", flag_o, 1'b0);

    // R6 directed: set wins over rollover, rollover ignored in mode 3
    mode_i = 3'd6; cmp2_hit_i = 1; rollover_i = 1; step(); idle();
    check("R6", "set beats rollover", flag_o, 1'b1);
    mode_i = 3'd3; rollover_i = 1; sec_edge_i = 1; step(); idle();
    check("R3", "rollover/sec ignored in toggle", flag_o, 1'b1);

    // R8 directed: force beats compare set
    mode_i = 3'd2; cmp1_hit_i = 1; force_wr_i = 1; force_val_i = 0; step(); idle();
    check("R8", "force overrides set", flag_o, 1'b0);
    force_wr_i = 1; force_val_i = 1; step(); idle();
    check("R8", "force loads 1", flag_o, 1'b1);

    // R9/R10 directed
    dbg_active_i = 1; dbg_ctl_i = 2'b10; pol_inv_i = 0; #1;
    check("R9", "debug forces pin low", pin_data_o, 1'b0);
    check("R9", "flag unaffected by debug", flag_o, 1'b1);
    pol_inv_i = 1; #1;
    check("R10", "debug low then inverted", pin_data_o, 1'b1);
    dbg_active_i = 0; #1;
    check("R10", "inverted flag", pin_data_o, 1'b0);
    pol_inv_i = 0; oe_i = 0; #1;
    check("R11", "pin quiet without oe", pin_data_o, 1'b0);
    @(negedge clk);

    // random phase
    for (int blk = 0; blk < 80; blk++) begin
      mode_i = 3'($urandom_range(0, 7));
      for (int c = 0; c < 40; c++) begin
        cmp1_hit_i   = ($urandom_range(0, 4) == 0);
        cmp2_hit_i   = ($urandom_range(0, 4) == 0);
        rollover_i   = ($urandom_range(0, 5) == 0);
        sec_edge_i   = ($urandom_range(0, 5) == 0);
        cnt_active_i = ($urandom_range(0, 3) != 0);
        tick_i       = $urandom_range(0, 1);
        force_wr_i   = ($urandom_range(0, 15) == 0);
        force_val_i  = $urandom_range(0, 1);
        dbg_active_i = ($urandom_range(0, 7) == 0);
        dbg_ctl_i    = 2'($urandom_range(0, 3));
        pol_inv_i    = ($urandom_range(0, 3) == 0);
        oe_i         = ($urandom_range(0, 5) != 0);
        step();
      end
    end
    done = 1'b1;
    finish_run();
  end
endmodule